// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable, cycle-accurate model of a word-wide synchronous SRAM. Reads and writes may follow each other in any order on consecutive clocks with no idle cycle between them, so one data word moves on every clock. The control pins, byte selects and address are registered on the rising edge. A read returns its data combinationally from the registered address in the cycle right after that edge, with no output register.

A write takes its address on one edge and its data and byte selects on the next edge. That second edge places the word in a pending-write registry, and the word reaches the array on the edge after that. A read whose address matches the registry is served from the registry for the selected bytes, so it never sees stale data. Other features are a clock-enable stall, three chip enables, an output enable that acts without the clock, and a two-bit burst counter with a choice of linear or interleaved order. The data bus is split into separate in, out and drive-enable signals.

The word count is set by the parameter ADDR_W. Its default of 10 keeps elaboration small, and 16 gives the full 65,536-word array. The data pins are fixed-timing pins with no handshake: the clock enable is the only way to hold the block back. While the clock enable is low, no transfer is accepted and nothing inside the block changes.

Top module: `ft_sram`

## Requirements
- R1: Each of the four 8-bit byte lanes (lane n is data bits 8n+7..8n) is written only when its active-low select bsel_n[n] is 0 on the data edge. A lane whose select is 1 keeps its previous contents.
- R2: A read loaded on an enabled edge (adv_ld=0, all chip enables active, we_n=1) drives dq_oe=1 and the addressed word on dq_out in the cycle right after that edge, provided oe_n=0.
- R3: Reads and writes may be mixed on consecutive enabled edges. A read of a word whose write data was taken on that same edge returns the new data, merged lane by lane over the old word.
- R4: On an edge where clk_en=0, no register or array word changes. The outputs keep their values, and a write waiting for its data takes that data on the next enabled edge.
- R5: A load edge where ce1_n=1, ce2=0 or ce3_n=1 is a deselect. There is no access, no array word changes, and dq_oe=0 in the following cycle.
- R6: dq_oe is 0 during the data cycle of every write, including every beat of a write burst.
- R7: oe_n=1 forces dq_oe=0 and dq_out=0 without waiting for a clock edge.
- R8: With burst_ilv=0, an edge with adv_ld=1 after a valid load moves to the next address. Its low two bits are (start+n) mod 4, the upper bits do not change, and the read or write type of the load is kept.
- R9: With burst_ilv=1, the low two address bits of beat n are start XOR n.
- R10: adv_ld=1 after a deselect keeps the block deselected. During a continue edge the chip enables and we_n are ignored.
- R11: Write data and byte selects are taken on the enabled edge after the address edge. Byte selects given on the address edge have no effect.
- R12: After reset, dq_oe is 0 and no access is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable, active high; low stalls the block |
| adv_ld | input | 1 | 0 loads a new address, 1 advances the burst |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low, sampled on load |
| bsel_n | input | 4 | Byte-lane write selects, active low, sampled on the data edge |
| addr | input | ADDR_W | Word address |
| burst_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Output enable, active low, acts without the clock |
| dq_in | input | 32 | Write data |
| dq_out | output | 32 | Read data, 0 while not driving |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
A stimulus table runs write-then-read pairs to different addresses, to tell the registered read path apart from the array contents. A read placed straight after a partial-byte write to the same address separates forwarding from the registry from a read of the stale array word. A write burst and a read burst that both start in the middle of an aligned group of four show whether the address wraps inside the group. The same reads repeated with interleaved order tell the XOR sequence apart from the linear one. Stalls placed inside a read burst and in the data cycle of a write, deselects made by each chip enable in turn, and oe_n toggled between clock edges check the freeze, deselect and asynchronous output-enable rules.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int BURST_W = 2;

  typedef struct packed {
    logic valid;
    logic write;
  } cmd_t;
endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
  import sram_pkg::*;
(
  input  logic [BURST_W-1:0] start_lo,
  input  logic [BURST_W-1:0] beat,
  input  logic               ilv,
  output logic [BURST_W-1:0] lo
);
  // Both orders stay inside the aligned group; the addition wraps modulo 4.
  always_comb begin
    if (ilv) lo = start_lo ^ beat;
    else     lo = start_lo + beat;
  end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[l]) bank[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
    end

    assign rd_data[l*LANE_W +: LANE_W] = bank[rd_addr];
  end
endmodule

// File: rtl/sram_write_registry.sv
module sram_write_registry #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en,
  input  logic                    capture,
  input  logic [ADDR_W-1:0]       cap_addr,
  input  logic [LANES*LANE_W-1:0] cap_data,
  input  logic [LANES-1:0]        cap_mask,
  output logic                    commit_en,
  output logic [ADDR_W-1:0]       commit_addr,
  output logic [LANES*LANE_W-1:0] commit_data,
  output logic [LANES-1:0]        commit_mask,
  input  logic [ADDR_W-1:0]       look_addr,
  input  logic [LANES*LANE_W-1:0] arr_data,
  output logic [LANES*LANE_W-1:0] fwd_data
);
  logic held_q;
  logic hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else if (clk_en) begin
      held_q <= capture;
    end
  end

  always_ff @(posedge clk) begin
    if (clk_en && capture) begin
      commit_addr <= cap_addr;
      commit_data <= cap_data;
      commit_mask <= cap_mask;
    end
  end

  // The held word drains into the array on the next enabled edge.
  assign commit_en = held_q & clk_en;
  assign hit       = held_q && (commit_addr == look_addr);

  for (genvar l = 0; l < LANES; l++) begin : g_fwd
    assign fwd_data[l*LANE_W +: LANE_W] = (hit && commit_mask[l])
        ? commit_data[l*LANE_W +: LANE_W]
        : arr_data[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/ft_sram.sv
module ft_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en,
  input  logic                    adv_ld,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    we_n,
  input  logic [LANES-1:0]        bsel_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    burst_ilv,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  localparam int DATA_W = LANES * LANE_W;

  logic               sel_now;
  cmd_t               cmd_q;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] beat_q;
  logic [BURST_W-1:0] lo_now;
  logic [ADDR_W-1:0]  cur_addr;

  logic               commit_en;
  logic [ADDR_W-1:0]  commit_addr;
  logic [DATA_W-1:0]  commit_data;
  logic [LANES-1:0]   commit_mask;
  logic [DATA_W-1:0]  arr_rd;
  logic [DATA_W-1:0]  fwd_rd;

  assign sel_now = ~ce1_n & ce2 & ~ce3_n;

  // Command and burst state; a continue edge keeps the loaded type.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      base_q <= '0;
      beat_q <= '0;
    end else if (clk_en) begin
      if (!adv_ld) begin
        cmd_q.valid <= sel_now;
        cmd_q.write <= ~we_n;
        base_q      <= addr;
        beat_q      <= '0;
      end else if (cmd_q.valid) begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  sram_burst_seq u_burst (
    .start_lo (base_q[BURST_W-1:0]),
    .beat     (beat_q),
    .ilv      (burst_ilv),
    .lo       (lo_now)
  );

  assign cur_addr = {base_q[ADDR_W-1:BURST_W], lo_now};

  sram_write_registry #(
    .ADDR_W (ADDR_W), .LANES (LANES), .LANE_W (LANE_W)
  ) u_wreg (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_en      (clk_en),
    .capture     (cmd_q.valid & cmd_q.write),
    .cap_addr    (cur_addr),
    .cap_data    (dq_in),
    .cap_mask    (~bsel_n),
    .commit_en   (commit_en),
    .commit_addr (commit_addr),
    .commit_data (commit_data),
    .commit_mask (commit_mask),
    .look_addr   (cur_addr),
    .arr_data    (arr_rd),
    .fwd_data    (fwd_rd)
  );

  sram_array #(
    .ADDR_W (ADDR_W), .LANES (LANES), .LANE_W (LANE_W)
  ) u_array (
    .clk     (clk),
    .wr_en   (commit_en),
    .wr_addr (commit_addr),
    .wr_data (commit_data),
    .wr_mask (commit_mask),
    .rd_addr (cur_addr),
    .rd_data (arr_rd)
  );

  assign dq_oe  = cmd_q.valid & ~cmd_q.write & ~oe_n;
  assign dq_out = dq_oe ? fwd_rd : '0;
endmodule

// File: rtl/ft_sram_checker.sv
module ft_sram_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              adv_ld,
  input logic              ce1_n,
  input logic              ce2,
  input logic              ce3_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic [DATA_W-1:0] dq_out
);
  logic sel;
  assign sel = ~ce1_n & ce2 & ~ce3_n;

  // R7: a high output enable keeps the bus undriven
  p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!dq_oe && dq_out == '0));

  // R6: no drive in the data cycle of a loaded write
  p_write_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(clk_en) && !$past(adv_ld) && $past(sel) && !$past(we_n))
    |-> !dq_oe);

  // R5: deselect load leaves the bus undriven
  p_deselect_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(clk_en) && !$past(adv_ld) && !$past(sel)) |-> !dq_oe);

  // R2: a loaded read drives in the next cycle
  p_read_flow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(clk_en) && !$past(adv_ld) && $past(sel) && $past(we_n) && !oe_n)
    |-> dq_oe);

  // R4: a stalled edge leaves the outputs unchanged
  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(clk_en) && $stable(oe_n)) |-> ($stable(dq_oe) && $stable(dq_out)));
endmodule

bind ft_sram ft_sram_checker #(.DATA_W(LANES * LANE_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .clk_en (clk_en),
  .adv_ld (adv_ld),
  .ce1_n  (ce1_n),
  .ce2    (ce2),
  .ce3_n  (ce3_n),
  .we_n   (we_n),
  .oe_n   (oe_n),
  .dq_oe  (dq_oe),
  .dq_out (dq_out)
);

// File: tb/ft_sram_bench.sv
module ft_sram_bench;
  localparam int AW = 10;

  typedef struct packed {
    logic        cke;
    logic        adv;
    logic [1:0]  cs;   // 0 selected, 1 ce1_n high, 2 ce2 low, 3 ce3_n high
    logic        wen;
    logic [3:0]  bs;
    logic [9:0]  a;
    logic [31:0] d;
    logic        oe;   // expected dq_oe after the edge
    logic [31:0] q;    // expected dq_out when oe is 1
    logic [3:0]  rq;   // requirement number reported on failure
  } vec_t;

  localparam int NV = 29;
  localparam vec_t TBL [NV] = '{
    // R6: write loads, data cycles
    '{1'b1,1'b0,2'd0,1'b0,4'hF,10'h010,32'h0,        1'b0,32'h0,        4'd6},
    '{1'b1,1'b0,2'd0,1'b0,4'h0,10'h011,32'h11112222, 1'b0,32'h0,        4'd6},
    // R2, R3: reads straight after writes
    '{1'b1,1'b0,2'd0,1'b1,4'h0,10'h010,32'h33334444, 1'b1,32'h11112222, 4'd2},
    '{1'b1,1'b0,2'd0,1'b1,4'hF,10'h011,32'h0,        1'b1,32'h33334444, 4'd3},
    // R11: selects on the address edge are ignored; R1, R3: partial merge forwarded
    '{1'b1,1'b0,2'd0,1'b0,4'hF,10'h011,32'h0,        1'b0,32'h0,        4'd11},
    '{1'b1,1'b0,2'd0,1'b1,4'hC,10'h011,32'hAAAABBBB, 1'b1,32'h3333BBBB, 4'd1},
    '{1'b1,1'b0,2'd0,1'b1,4'hF,10'h011,32'h0,        1'b1,32'h3333BBBB, 4'd1},
    // R8: linear write burst from 0x022, wraps into the group
    '{1'b1,1'b0,2'd0,1'b0,4'hF,10'h022,32'h0,        1'b0,32'h0,        4'd8},
    '{1'b1,1'b1,2'd0,1'b1,4'h0,10'h000,32'hA0A0A0A0, 1'b0,32'h0,        4'd6},
    '{1'b1,1'b1,2'd0,1'b1,4'h0,10'h000,32'hA1A1A1A1, 1'b0,32'h0,        4'd6},
    '{1'b1,1'b1,2'd0,1'b1,4'h0,10'h000,32'hA2A2A2A2, 1'b0,32'h0,        4'd6},
    '{1'b1,1'b1,2'd0,1'b1,4'h0,10'h000,32'hA3A3A3A3, 1'b0,32'h0,        4'd6},
    '{1'b1,1'b0,2'd0,1'b1,4'h0,10'h021,32'hA4A4A4A4, 1'b1,32'hA3A3A3A3, 4'd8},
    '{1'b1,1'b0,2'd0,1'b1,4'hF,10'h020,32'h0,        1'b1,32'hA2A2A2A2, 4'd8},
    '{1'b1,1'b0,2'd0,1'b1,4'hF,10'h022,32'h0,        1'b1,32'hA4A4A4A4, 4'd8},
    '{1'b1,1'b0,2'd0,1'b1,4'hF,10'h023,32'h0,        1'b1,32'hA1A1A1A1, 4'd8},
    // R8: linear read burst from 0x023
    '{1'b1,1'b0,2'd0,1'b1,4'hF,10'h023,32'h0,        1'b1,32'hA1A1A1A1, 4'd8},
    '{1'b1,1'b1,2'd0,1'b1,4'hF,10'h000,32'h0,        1'b1,32'hA2A2A2A2, 4'd8},
    '{1'b1,1'b1,2'd0,1'b1,4'hF,10'h000,32'h0,        1'b1,32'hA3A3A3A3, 4'd8},
    '{1'b1,1'b1,2'd0,1'b1,4'hF,10'h000,32'h0,        1'b1,32'hA4A4A4A4, 4'd8},
    // R4: stalled load ignored, burst resumes
    '{1'b0,1'b0,2'd0,1'b1,4'hF,10'h010,32'h0,        1'b1,32'hA4A4A4A4, 4'd4},
    '{1'b1,1'b1,2'd0,1'b1,4'hF,10'h000,32'h0,        1'b1,32'hA1A1A1A1, 4'd4},
    // R5, R10: deselected write, continue stays deselected, word untouched
    '{1'b1,1'b0,2'd2,1'b0,4'h0,10'h010,32'hDEADBEEF, 1'b0,32'h0,        4'd5},
    '{1'b1,1'b1,2'd0,1'b0,4'h0,10'h010,32'hDEADBEEF, 1'b0,32'h0,        4'd10},
    '{1'b1,1'b0,2'd0,1'b1,4'h0,10'h010,32'hDEADBEEF, 1'b1,32'h11112222, 4'd5},
    // R4, R11: stall inside a write data cycle
    '{1'b1,1'b0,2'd0,1'b0,4'hF,10'h030,32'h0,        1'b0,32'h0,        4'd11},
    '{1'b0,1'b0,2'd0,1'b1,4'h0,10'h000,32'hBAD0BAD0, 1'b0,32'h0,        4'd4},
    '{1'b1,1'b0,2'd0,1'b1,4'h0,10'h030,32'h55667788, 1'b1,32'h55667788, 4'd11},
    '{1'b1,1'b0,2'd0,1'b1,4'hF,10'h030,32'h0,        1'b1,32'h55667788, 4'd4}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en = 1'b1;
  logic          adv_ld = 1'b0;
  logic          ce1_n = 1'b1;
  logic          ce2 = 1'b0;
  logic          ce3_n = 1'b1;
  logic          we_n = 1'b1;
  logic [3:0]    bsel_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic          burst_ilv = 1'b0;
  logic          oe_n = 1'b0;
  logic [31:0]   dq_in = '0;
  logic [31:0]   dq_out;
  logic          dq_oe;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ft_sram #(.ADDR_W(AW)) u_ft_sram (
    .clk (clk), .rst_n (rst_n), .clk_en (clk_en), .adv_ld (adv_ld),
    .ce1_n (ce1_n), .ce2 (ce2), .ce3_n (ce3_n), .we_n (we_n),
    .bsel_n (bsel_n), .addr (addr), .burst_ilv (burst_ilv), .oe_n (oe_n),
    .dq_in (dq_in), .dq_out (dq_out), .dq_oe (dq_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic cke, input logic adv, input logic [1:0] cs,
                      input logic wen, input logic [3:0] bs,
                      input logic [AW-1:0] a, input logic [31:0] d);
    clk_en = cke; adv_ld = adv;
    ce1_n = (cs == 2'd1); ce2 = (cs != 2'd2); ce3_n = (cs == 2'd3);
    we_n = wen; bsel_n = bs; addr = a; dq_in = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    chk("R12 dq_oe in reset", {31'b0, dq_oe}, 32'h0);
    rst_n = 1'b1;
    step(1'b1, 1'b1, 2'd0, 1'b1, 4'hF, '0, '0);
    chk("R12 continue after reset stays idle", {31'b0, dq_oe}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].cke, TBL[i].adv, TBL[i].cs, TBL[i].wen, TBL[i].bs, TBL[i].a, TBL[i].d);
      n_checks++;
      if (dq_oe !== TBL[i].oe || (TBL[i].oe && dq_out !== TBL[i].q)) begin
        n_err++;
        $display("FAIL R%0d row %0d: actual oe=%b q=%h expected oe=%b q=%h",
                 TBL[i].rq, i, dq_oe, dq_out, TBL[i].oe, TBL[i].q);
      end
    end

    // R7: output enable acts between edges (a read of 0x030 is in its output cycle)
    oe_n = 1'b1;
    #1;
    chk("R7 oe_n high drive", {31'b0, dq_oe}, 32'h0);
    chk("R7 oe_n high data", dq_out, 32'h0);
    oe_n = 1'b0;
    #1;
    chk("R7 oe_n low drive", {31'b0, dq_oe}, 32'h1);

    // R9: interleaved order from start 1 gives 1,0,3,2
    burst_ilv = 1'b1;
    step(1'b1, 1'b0, 2'd0, 1'b0, 4'hF, 10'h040, 32'h0);
    step(1'b1, 1'b0, 2'd0, 1'b0, 4'h0, 10'h041, 32'hB0000040);
    step(1'b1, 1'b0, 2'd0, 1'b0, 4'h0, 10'h042, 32'hB0000041);
    step(1'b1, 1'b0, 2'd0, 1'b0, 4'h0, 10'h043, 32'hB0000042);
    step(1'b1, 1'b0, 2'd0, 1'b1, 4'h0, 10'h041, 32'hB0000043);
    chk("R9 beat0", dq_out, 32'hB0000041);
    step(1'b1, 1'b1, 2'd0, 1'b1, 4'hF, '0, '0);
    chk("R9 beat1", dq_out, 32'hB0000040);
    step(1'b1, 1'b1, 2'd0, 1'b1, 4'hF, '0, '0);
    chk("R9 beat2", dq_out, 32'hB0000043);
    step(1'b1, 1'b1, 2'd0, 1'b1, 4'hF, '0, '0);
    chk("R9 beat3", dq_out, 32'hB0000042);

    // R5: each chip enable alone deselects
    step(1'b1, 1'b0, 2'd1, 1'b1, 4'hF, 10'h041, '0);
    chk("R5 ce1_n high", {31'b0, dq_oe}, 32'h0);
    step(1'b1, 1'b0, 2'd3, 1'b1, 4'hF, 10'h041, '0);
    chk("R5 ce3_n high", {31'b0, dq_oe}, 32'h0);
    step(1'b1, 1'b0, 2'd0, 1'b1, 4'hF, 10'h041, '0);
    chk("R5 reselected read", dq_out, 32'hB0000041);

    // R12: reset mid-run clears the pending read
    rst_n = 1'b0;
    #1;
    chk("R12 async reset", {31'b0, dq_oe}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b1, 2'd0, 1'b1, 4'hF, '0, '0);
    chk("R12 idle after reset", {31'b0, dq_oe}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule